// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of transfers set up ahead of time, so no processor takes part while the list runs. Software writes three things through a small register port: per-entry command words into a command store, outgoing bytes into a transmit byte store, and the first and last queue indices. It then writes the start bit. The block steps through the entries in order and shifts each one as an 8-bit or a 16-bit word. Between entries it keeps chip select low or releases it, as each command asks. It stores the incoming bytes in a receive byte store and sets a sticky completion flag when the last entry is done.

Byte slots are interleaved by queue index. A 16-bit entry q uses slots 2q and 2q+1 for both directions. An 8-bit entry q sends slot 2q and stores what it receives in slot 2q+1. The serial clock divider is clamped to a legal range. Both clock polarities and both clock phases are supported. A hold option keeps chip select low after a run ends, so that the next run continues the same frame.

Top module: `spi_queue_master`

## Requirements
- R1: Each SCK half-period lasts E system clock cycles, where E is the divider register (address 0x00) clamped to the range DIV_MIN..DIV_MAX (defaults 2 and 40).
- R2: The mode register (address 0x01) has three bits: bit0 selects the clock phase, bit1 the clock polarity and bit2 master enable. SCK rests at the polarity level. With phase 0, MISO is sampled on the leading SCK edge. With phase 1, it is sampled on the trailing edge.
- R3: A run starts at the entry held in the start-index register (0x02). It advances by one index at a time, wrapping from 15 to 0, and ends after the entry held in the end-index register (0x03), inclusive.
- R4: A command entry (addresses 0x20+q) with bit1 set is shifted as a 16-bit word. The byte in the lower slot goes out first. With bit1 clear the entry is an 8-bit word. Data is sent most significant bit first.
- R5: Transmit slots are at 0x40+s and receive slots at 0x60+s. A 16-bit entry q sends slots 2q and 2q+1 and stores its received bytes in those same receive slots. An 8-bit entry q sends slot 2q and stores its byte in receive slot 2q+1.
- R6: For an entry that is not the last in the run, command bit0 set keeps chip select low into the next entry. With bit0 clear, chip select rises for one half-period before the next entry.
- R7: After the last entry, chip select rises unless bit1 of the control register (0x04) was 1 in the write that started the run. In that case it stays low through idle, and a following run continues the frame without a rising edge.
- R8: Command bits 3:2 choose which csn_o line is driven low. At most one line is low at any time.
- R9: Writing the control register with bit0 set starts a run, but only when master enable is set and no run is active. Bit0 of the status register (0x05) becomes 1 when the run ends and stays 1 until any write to the status register.
- R10: After reset all csn_o lines are high, SCK is low, and the status register, control register and receive slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 7 | Register and store address |
| reg_wdata_i | input | 16 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| csn_o | output | NUM_CS | Active-low chip selects |

## Verification
The assertions take three things for granted. The polarity, phase, end-index and divider registers are not rewritten while a run is active. Status writes do not collide with the completion cycle. At most one write arrives per cycle. The stimulus reprograms the block only after it has read back the completion flag, and it clears status only while idle. The bench ties MISO to MOSI, optionally inverted, so every received byte has a known value whatever the clock mode.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int ADDR_W = 7;
  localparam int PCS_W  = 2;

  typedef struct packed {
    logic [PCS_W-1:0] pcs;
    logic             wide;
    logic             cont;
  } sq_cmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_XFER,
    SQ_WB,
    SQ_GAP
  } sq_state_e;

  localparam logic [ADDR_W-1:0] A_DIV    = 7'h00;
  localparam logic [ADDR_W-1:0] A_MODE   = 7'h01;
  localparam logic [ADDR_W-1:0] A_QSTART = 7'h02;
  localparam logic [ADDR_W-1:0] A_QEND   = 7'h03;
  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 7'h05;

  localparam logic [1:0] RG_REG = 2'b00;
  localparam logic [1:0] RG_CMD = 2'b01;
  localparam logic [1:0] RG_TX  = 2'b10;
  localparam logic [1:0] RG_RX  = 2'b11;
endpackage

// File: rtl/sq_divider.sv
module sq_divider #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] eff, cnt_q;

  always_comb begin
    eff = div_i;
    if (div_i < LO)      eff = LO;
    else if (div_i > HI) eff = HI;
  end

  assign tick_o = run_i && (cnt_q == eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  // half-period never shorter than two cycles
  p_tick_spaced_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sq_shift.sv
module sq_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              ph_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_q    <= '0;
      ph_q    <= 1'b0;
      first_q <= 1'b1;
    end else if (load_i) begin
      tx_q    <= word_i;
      ph_q    <= 1'b0;
      first_q <= 1'b1;
    end else begin
      if (lead_i) begin
        ph_q    <= 1'b1;
        first_q <= 1'b0;
        if (cpha_i && !first_q) tx_q <= tx_q << 1;
        if (!cpha_i)            rx_q <= {rx_q[WORD_W-2:0], miso_i};
      end
      if (trail_i) begin
        ph_q <= 1'b0;
        if (!cpha_i) tx_q <= tx_q << 1;
        if (cpha_i)  rx_q <= {rx_q[WORD_W-2:0], miso_i};
      end
    end
  end

  assign sck_o  = cpol_i ^ ph_q;
  assign mosi_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;

  p_load_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !(lead_i || trail_i));
  p_edge_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_i && trail_i));
endmodule

// File: rtl/sq_seq.sv
module sq_seq
  import sq_pkg::*;
#(
  parameter int QW     = 4,
  parameter int WORD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic [QW-1:0]    qstart_i,
  input  logic [QW-1:0]    qend_i,
  input  sq_cmd_t          cmd_i,
  input  logic             tick_i,
  output logic [QW-1:0]    ptr_o,
  output logic             busy_o,
  output logic             run_o,
  output logic             load_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             rx_we_o,
  output logic             wide_o,
  output logic             done_o,
  output logic             cs_act_o,
  output logic [PCS_W-1:0] cs_idx_o
);
  localparam int HC_W = $clog2(2 * WORD_W);

  sq_state_e        state_q;
  logic [QW-1:0]    ptr_q;
  logic [HC_W-1:0]  hc_q, hc_last;
  logic             wide_q, cont_q, hold_q, cs_act_q;
  logic [PCS_W-1:0] cs_idx_q;
  logic             last_entry, keep;

  assign hc_last    = wide_q ? HC_W'(2 * WORD_W - 1) : HC_W'(WORD_W - 1);
  assign last_entry = (ptr_q == qend_i);
  assign keep       = last_entry ? hold_q : cont_q;

  assign busy_o   = (state_q != SQ_IDLE);
  assign run_o    = (state_q == SQ_SETUP) || (state_q == SQ_XFER) || (state_q == SQ_GAP);
  assign load_o   = (state_q == SQ_SETUP);
  assign lead_o   = (state_q == SQ_XFER) && tick_i && !hc_q[0];
  assign trail_o  = (state_q == SQ_XFER) && tick_i &&  hc_q[0];
  assign rx_we_o  = (state_q == SQ_WB);
  assign done_o   = ((state_q == SQ_WB) && keep && last_entry) ||
                    ((state_q == SQ_GAP) && tick_i && last_entry);
  assign ptr_o    = ptr_q;
  assign wide_o   = wide_q;
  assign cs_act_o = cs_act_q;
  assign cs_idx_o = cs_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      ptr_q    <= '0;
      hc_q     <= '0;
      wide_q   <= 1'b0;
      cont_q   <= 1'b0;
      hold_q   <= 1'b0;
      cs_act_q <= 1'b0;
      cs_idx_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          ptr_q   <= qstart_i;
          hold_q  <= hold_i;
          state_q <= SQ_SETUP;
        end
        SQ_SETUP: begin
          cs_act_q <= 1'b1;
          cs_idx_q <= cmd_i.pcs;
          wide_q   <= cmd_i.wide;
          cont_q   <= cmd_i.cont;
          hc_q     <= '0;
          if (tick_i) state_q <= SQ_XFER;
        end
        SQ_XFER: if (tick_i) begin
          hc_q <= hc_q + HC_W'(1);
          if (hc_q == hc_last) state_q <= SQ_WB;
        end
        SQ_WB: begin
          if (!keep) begin
            cs_act_q <= 1'b0;
            state_q  <= SQ_GAP;
          end else if (last_entry) begin
            state_q <= SQ_IDLE;
          end else begin
            ptr_q   <= ptr_q + QW'(1);
            state_q <= SQ_SETUP;
          end
        end
        SQ_GAP: if (tick_i) begin
          if (last_entry) state_q <= SQ_IDLE;
          else begin
            ptr_q   <= ptr_q + QW'(1);
            state_q <= SQ_SETUP;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_stop_at_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ptr_q == $past(qend_i));
  p_gap_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_GAP) |-> !cs_act_q);
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import sq_pkg::*;
#(
  parameter int NUM_CMD = 16,
  parameter int NUM_CS  = 4,
  parameter int DATA_W  = 16,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               reg_we_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_CS-1:0]  csn_o
);
  localparam int QW       = $clog2(NUM_CMD);
  localparam int NUM_SLOT = 2 * NUM_CMD;
  localparam int SW       = $clog2(NUM_SLOT);
  localparam int BYTE_W   = DATA_W / 2;

  logic [DATA_W-1:0] div_q;
  logic              cpha_q, cpol_q, master_q, hold_q, done_q;
  logic [QW-1:0]     qstart_q, qend_q;
  sq_cmd_t           cmd_mem [NUM_CMD];
  logic [BYTE_W-1:0] tx_mem  [NUM_SLOT];
  logic [BYTE_W-1:0] rx_mem  [NUM_SLOT];

  logic [1:0]        region;
  logic [QW-1:0]     cmd_idx;
  logic [SW-1:0]     slot_idx;
  logic              start, busy, run, load, lead, trail, rx_we, wide, done_pulse, tick;
  logic              cs_act;
  logic [PCS_W-1:0]  cs_idx;
  logic [QW-1:0]     ptr;
  sq_cmd_t           cur_cmd;
  logic [DATA_W-1:0] tx_word, rx_word;

  assign region   = reg_addr_i[ADDR_W-1 -: 2];
  assign cmd_idx  = reg_addr_i[QW-1:0];
  assign slot_idx = reg_addr_i[SW-1:0];
  assign start    = reg_we_i && (reg_addr_i == A_CTRL) && reg_wdata_i[0] && master_q && !busy;

  assign cur_cmd = cmd_mem[ptr];
  assign tx_word = {tx_mem[{ptr, 1'b0}], cur_cmd.wide ? tx_mem[{ptr, 1'b1}] : BYTE_W'(0)};

  // register file and stores
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      cpha_q   <= 1'b0;
      cpol_q   <= 1'b0;
      master_q <= 1'b0;
      qstart_q <= '0;
      qend_q   <= '0;
      hold_q   <= 1'b0;
      done_q   <= 1'b0;
      for (int i = 0; i < NUM_CMD; i++) cmd_mem[i] <= '0;
      for (int i = 0; i < NUM_SLOT; i++) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end
    end else begin
      if (reg_we_i) begin
        unique case (region)
          RG_REG: begin
            case (reg_addr_i)
              A_DIV:    div_q <= reg_wdata_i;
              A_MODE:   {master_q, cpol_q, cpha_q} <= reg_wdata_i[2:0];
              A_QSTART: qstart_q <= reg_wdata_i[QW-1:0];
              A_QEND:   qend_q <= reg_wdata_i[QW-1:0];
              A_CTRL:   hold_q <= reg_wdata_i[1];
              A_STAT:   done_q <= 1'b0;
              default: ;
            endcase
          end
          RG_CMD:  cmd_mem[cmd_idx] <= sq_cmd_t'(reg_wdata_i[3:0]);
          RG_TX:   tx_mem[slot_idx] <= reg_wdata_i[BYTE_W-1:0];
          default: ;
        endcase
      end
      if (done_pulse) done_q <= 1'b1;
      if (rx_we) begin
        if (wide) begin
          rx_mem[{ptr, 1'b0}] <= rx_word[DATA_W-1:BYTE_W];
          rx_mem[{ptr, 1'b1}] <= rx_word[BYTE_W-1:0];
        end else begin
          rx_mem[{ptr, 1'b1}] <= rx_word[BYTE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (region)
      RG_REG: begin
        case (reg_addr_i)
          A_DIV:    reg_rdata_o = div_q;
          A_MODE:   reg_rdata_o = DATA_W'({master_q, cpol_q, cpha_q});
          A_QSTART: reg_rdata_o = DATA_W'(qstart_q);
          A_QEND:   reg_rdata_o = DATA_W'(qend_q);
          A_CTRL:   reg_rdata_o = DATA_W'({hold_q, busy});
          A_STAT:   reg_rdata_o = DATA_W'(done_q);
          default:  reg_rdata_o = '0;
        endcase
      end
      RG_CMD:  reg_rdata_o = DATA_W'({cmd_mem[cmd_idx]});
      RG_TX:   reg_rdata_o = DATA_W'(tx_mem[slot_idx]);
      default: reg_rdata_o = DATA_W'(rx_mem[slot_idx]);
    endcase
  end

  sq_divider #(
    .DIV_W  (DATA_W),
    .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX)
  ) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_q),
    .tick_o(tick)
  );

  sq_seq #(
    .QW    (QW),
    .WORD_W(DATA_W)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hold_i  (reg_wdata_i[1]),
    .qstart_i(qstart_q),
    .qend_i  (qend_q),
    .cmd_i   (cur_cmd),
    .tick_i  (tick),
    .ptr_o   (ptr),
    .busy_o  (busy),
    .run_o   (run),
    .load_o  (load),
    .lead_o  (lead),
    .trail_o (trail),
    .rx_we_o (rx_we),
    .wide_o  (wide),
    .done_o  (done_pulse),
    .cs_act_o(cs_act),
    .cs_idx_o(cs_idx)
  );

  sq_shift #(
    .WORD_W(DATA_W)
  ) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (tx_word),
    .lead_i (lead),
    .trail_i(trail),
    .cpol_i (cpol_q),
    .cpha_i (cpha_q),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_word)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign csn_o[g] = !(cs_act && (cs_idx == PCS_W'(g)));
  end

  p_cs_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~csn_o));
  p_sck_rest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o == cpol_q);
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !(reg_we_i && reg_addr_i == A_STAT) |=> done_q);
endmodule

// File: tb/test_spi_queue_master.sv
`timescale 1ns/1ps
module test_spi_queue_master;
  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic [7:0]  div;
    logic [3:0]  qs;
    logic [3:0]  qe;
    logic [15:0] wide;
    logic [15:0] cont;
    logic [1:0]  pcs;
    logic        inv;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd3,   4'd0,  4'd3,  16'h0000, 16'hFFFF, 2'd0, 1'b0},
    '{1'b1, 1'b1, 8'd0,   4'd2,  4'd5,  16'h0014, 16'hFFF7, 2'd2, 1'b1},
    '{1'b0, 1'b1, 8'd200, 4'd7,  4'd7,  16'h0080, 16'h0000, 2'd1, 1'b0},
    '{1'b1, 1'b0, 8'd5,   4'd14, 4'd1,  16'h8002, 16'hBFFF, 2'd3, 1'b1},
    '{1'b0, 1'b0, 8'd2,   4'd0,  4'd15, 16'hA5A5, 16'hFFFF, 2'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  addr;
  logic [15:0] wdata, rdata;
  logic        we;
  logic        sck, mosi, miso;
  logic [3:0]  csn;
  logic        inv;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_queue_master i_spi_queue_master (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_we_i   (we),
    .reg_rdata_o(rdata),
    .sck_o      (sck),
    .mosi_o     (mosi),
    .miso_i     (miso),
    .csn_o      (csn)
  );

  // bus-side monitors
  logic       mon_en = 1'b0;
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0;
  int         cur_pcs = 0;
  int         edges = 0, nbits = 0, rises = 0, stray = 0;
  realtime    t0 = 0, t1 = 0;
  logic [7:0] sh = '0;
  logic [7:0] got [64];
  logic [3:0] csn_prev = 4'hF;

  always @(sck) if (mon_en) begin
    edges++;
    if (edges == 1) t0 = $realtime;
    if (edges == 2) t1 = $realtime;
    if ((sck != cur_cpol) == !cur_cpha) begin
      sh = {sh[6:0], mosi};
      nbits++;
      if (nbits % 8 == 0 && nbits <= 512) got[nbits/8-1] = sh;
    end
  end

  always @(csn) begin
    if (mon_en) begin
      for (int i = 0; i < 4; i++) begin
        if (i == cur_pcs && csn[i] && !csn_prev[i]) rises++;
        if (i != cur_pcs && !csn[i] && csn_prev[i]) stray++;
      end
    end
    csn_prev = csn;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr  = 7'(a);
    wdata = 16'(d);
    we    = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 7'(a);
    #1 d = int'(rdata);
  endtask

  task automatic wait_done(input string req);
    int s;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h05, s);
      if (s[0]) return;
    end
    chk({req, " timeout"}, 0, 1);
  endtask

  task automatic mon_reset();
    edges = 0; nbits = 0; rises = 0; stray = 0; sh = '0;
  endtask

  function automatic logic [7:0] txb(input int v, input int s);
    return 8'((s * 29 + v * 53 + 7) % 256);
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    int list [16];
    int n, e, nb, exp_r, eff;
    logic [7:0] expb [64];
    vec_t v;

    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; inv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 csn reset", int'(csn), 15);
    chk("R10 sck reset", int'(sck), 0);
    rst_n = 1'b1;
    rd(7'h05, r); chk("R10 status reset", r, 0);
    rd(7'h04, r); chk("R10 ctrl reset", r, 0);
    rd(7'h61, r); chk("R10 rx slot reset", r, 0);

    // table-driven runs
    for (int vi = 0; vi < NV; vi++) begin
      v = VECS[vi];
      n = 0; e = int'(v.qs);
      forever begin
        list[n++] = e;
        if (e == int'(v.qe)) break;
        e = (e + 1) % 16;
      end
      wr(7'h00, int'(v.div));
      wr(7'h01, 4 | (int'(v.cpol) << 1) | int'(v.cpha));
      nb = 0; exp_r = 0;
      for (int k = 0; k < n; k++) begin
        e = list[k];
        wr(7'h20 + e, (int'(v.pcs) << 2) | (int'(v.wide[e]) << 1) | int'(v.cont[e]));
        wr(7'h40 + 2*e, int'(txb(vi, 2*e)));
        expb[nb++] = txb(vi, 2*e);
        if (v.wide[e]) begin
          wr(7'h40 + 2*e + 1, int'(txb(vi, 2*e + 1)));
          expb[nb++] = txb(vi, 2*e + 1);
        end
        if (k < n - 1 && !v.cont[e]) exp_r++;
      end
      exp_r++;
      wr(7'h02, int'(v.qs));
      wr(7'h03, int'(v.qe));
      wr(7'h05, 0);
      cur_cpol = v.cpol; cur_cpha = v.cpha; cur_pcs = int'(v.pcs); inv = v.inv;
      mon_reset();
      mon_en = 1'b1;
      wr(7'h04, 1);
      wait_done("R9");
      repeat (4) @(negedge clk);
      mon_en = 1'b0;
      rd(7'h05, r); chk("R9 done set", r, 1);
      chk("R4 bit count", nbits, 8 * nb);
      for (int k = 0; k < nb; k++) chk("R3 R4 byte order", int'(got[k]), int'(expb[k]));
      for (int k = 0; k < n; k++) begin
        e = list[k];
        if (v.wide[e]) begin
          rd(7'h60 + 2*e, r);     chk("R5 wide rx low slot", r, int'(txb(vi, 2*e) ^ {8{v.inv}}));
          rd(7'h60 + 2*e + 1, r); chk("R5 wide rx high slot", r, int'(txb(vi, 2*e + 1) ^ {8{v.inv}}));
        end else begin
          rd(7'h60 + 2*e + 1, r); chk("R5 narrow rx odd slot", r, int'(txb(vi, 2*e) ^ {8{v.inv}}));
        end
      end
      chk("R6 cs rises", rises, exp_r);
      chk("R7 cs released", int'(csn), 15);
      chk("R8 other cs lines", stray, 0);
      eff = (v.div < 2) ? 2 : (v.div > 40) ? 40 : int'(v.div);
      chk("R1 half period ns", int'(t1 - t0), eff * 4);
      chk("R2 sck rest", int'(sck), int'(v.cpol));
    end

    // status clear
    wr(7'h05, 0);
    rd(7'h05, r); chk("R9 status clear", r, 0);

    // start ignored without master enable
    wr(7'h01, 0);
    cur_cpol = 1'b0; cur_cpha = 1'b0; cur_pcs = 0; inv = 1'b0;
    mon_reset();
    mon_en = 1'b1;
    wr(7'h04, 1);
    repeat (200) @(negedge clk);
    mon_en = 1'b0;
    rd(7'h05, r); chk("R9 no run without master", r, 0);
    chk("R9 no sck without master", edges, 0);

    // hold chip select across runs
    wr(7'h01, 4);
    wr(7'h00, 2);
    wr(7'h20, 0);
    wr(7'h40, 8'h3C);
    wr(7'h02, 0);
    wr(7'h03, 0);
    mon_reset();
    mon_en = 1'b1;
    wr(7'h04, 3);
    wait_done("R7");
    repeat (4) @(negedge clk);
    chk("R7 hold no rise", rises, 0);
    chk("R7 hold cs low", int'(csn[0]), 0);
    wr(7'h05, 0);
    wr(7'h04, 1);
    wait_done("R7");
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    chk("R7 extended frame bits", nbits, 16);
    chk("R7 single rise", rises, 1);
    chk("R7 final release", int'(csn), 15);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule